// File: doc/BRIEF.md
# Exponential Argument Reduction Unit

This block is the front end of a table-plus-Taylor exponential evaluator. It accepts an IEEE-754 double-precision operand `x`, converts it to signed fixed point, and splits it into an integer power-of-two part `k = floor(x * log2 e)` and a reduced remainder `f = x - k * ln2`. The remainder always lies in `[0, ln2)`. The operand's sign is carried only by `k`, so a negative operand with a non-zero remainder yields `-(k+1)` together with the complemented remainder. Downstream tables therefore never need a sign address bit.

The remainder is delivered as three 9-bit table addresses, taken from the most significant end down, and a Taylor tail made of all lower bits. Special operands are classified on the way through. NaN raises a flag. An operand whose `k` falls outside the 11-bit signed range raises an overflow flag when positive and an underflow flag when negative. Any flagged result has all data outputs forced to zero. The pipeline accepts one operand per clock with no backpressure, and a valid bit travels alongside the data.

Top module: `exr_arg_reduce`

## Requirements
- R1: For every unflagged result, `out_int * ln2 + frac` is no larger than the fixed-point input `X = trunc(|x| * 2^60) * sign(x)` and is less than one LSB (2^-60) below it. Here `frac` is the 60-bit concatenation `{out_tbl_hi, out_tbl_mid, out_tbl_lo, out_taylor}` read as a fraction.
- R2: `out_int` equals `floor(X / ln2)` as an 11-bit two's-complement value, including negative operands, where the sign moves entirely into the integer.
- R3: The reduced fraction is non-negative and strictly below ln2 for every unflagged result, whatever the operand's sign.
- R4: Field positions within the reduced fraction are as follows. `out_tbl_hi` holds weights 2^-1..2^-9, `out_tbl_mid` holds 2^-10..2^-18, `out_tbl_lo` holds 2^-19..2^-27, and `out_taylor` (33 bits) holds 2^-28..2^-60, each with its MSB at the higher weight.
- R5: An operand of magnitude below 2^-60 (exponent field below 963, zeros and subnormals included) converts to `X = 0`, giving `out_int = 0` and all fraction fields zero with no flag.
- R6: A NaN operand (exponent field all ones, mantissa non-zero) sets `out_nan` only, and all data outputs are zero.
- R7: A positive operand with `floor(X/ln2) > 1023`, or with exponent field at least 1034 (infinity included), sets `out_ovf` only. A negative operand with `floor(X/ln2) < -1024`, or with exponent field at least 1034, sets `out_unf` only. Data outputs are zero in both cases, and at most one flag is ever set.
- R8: Each accepted operand produces exactly one result 9 cycles after it is sampled. Results come in input order, and back-to-back operands are accepted every cycle.
- R9: During and after reset, with no accepted input, `out_valid` stays low and the data outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 64 | IEEE-754 double operand |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | 11 | Signed integer part k |
| out_tbl_hi | output | 9 | Fraction bits 2^-1..2^-9 |
| out_tbl_mid | output | 9 | Fraction bits 2^-10..2^-18 |
| out_tbl_lo | output | 9 | Fraction bits 2^-19..2^-27 |
| out_taylor | output | 33 | Fraction bits 2^-28..2^-60 |
| out_nan | output | 1 | Operand was NaN |
| out_ovf | output | 1 | Positive operand, integer part above range |
| out_unf | output | 1 | Negative operand, integer part below range |

## Verification
A sweep covers every exponent from well below the zero threshold up past the range limit, with eight mantissa patterns and both signs. This separates the shift direction and amount of the conversion, the sign migration, and the transition into the range flags. A second set places operands at multiples of ln2 and one ulp either side of them. There the constant multiplier's floor estimate can be off by one, so only a working correction step yields the exact integer and a fraction inside `[0, ln2)`. A third set of specials (signed zeros, subnormals, the 2^-60 boundary, infinities, quiet and signalling NaN, the largest finite value) checks the tiny-operand rule and the mutual exclusion of the flags.

// File: rtl/exr_pkg.sv
package exr_pkg;

   localparam int FP_W   = 64;
   localparam int EXP_W  = 11;
   localparam int MAN_W  = 52;
   localparam int BIAS   = 1023;

   // ln2 with 72 fraction bits, rounded to nearest
   localparam int          LN2_FB  = 72;
   localparam logic [71:0] LN2_Q72 = 72'hB17217F7D1CF79ABCA;

   // log2(e) with 64 fraction bits (one integer bit), truncated
   localparam int          L2E_FB    = 64;
   localparam logic [64:0] LOG2E_Q64 = 65'h1_71547652B82FE177;

   typedef struct packed {
      logic nan;   // not-a-number operand
      logic big;   // magnitude beyond fixed-point range (incl. infinity)
      logic neg;   // operand sign
   } exr_cls_t;

   localparam int CLS_W = $bits(exr_cls_t);

endpackage

// File: rtl/exr_delay.sv
module exr_delay #(
   parameter int W = 1,
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (N == 0) begin : g_wire
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] stg [N];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < N; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[N-1];
      end
   endgenerate

endmodule

// File: rtl/exr_unpack.sv
module exr_unpack
   import exr_pkg::*;
#(
   parameter int INT_W  = 11,
   parameter int FRAC_W = 60,
   parameter int LAT    = 5,
   localparam int X_W   = INT_W + FRAC_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  vld_i,
   input  logic [FP_W-1:0]       op_i,
   output logic                  vld_o,
   output logic signed [X_W-1:0] x_o,
   output exr_cls_t              cls_o
);

   localparam int SH0    = BIAS + MAN_W - FRAC_W;  // exponent giving unit shift
   localparam int BIG_E  = BIAS + INT_W;           // first exponent out of range
   localparam int TINY_E = BIAS - FRAC_W;          // below this, x truncates to 0
   localparam int BND_W  = 1 + CLS_W + X_W;

   logic                  neg_c, nan_c, big_c;
   logic [EXP_W-1:0]      ex_c;
   logic [MAN_W-1:0]      mt_c;
   logic [X_W-1:0]        sig_c, mag_c;
   logic signed [X_W-1:0] x_c;

   always_comb begin
      neg_c = op_i[FP_W-1];
      ex_c  = op_i[FP_W-2 -: EXP_W];
      mt_c  = op_i[MAN_W-1:0];
      nan_c = (ex_c == '1) && (mt_c != '0);
      big_c = !nan_c && (ex_c >= EXP_W'(BIG_E));
      sig_c = (ex_c == '0) ? '0 : X_W'({1'b1, mt_c});
      if (ex_c >= EXP_W'(SH0)) mag_c = sig_c << (ex_c - EXP_W'(SH0));
      else                     mag_c = sig_c >> (EXP_W'(SH0) - ex_c);
      if (nan_c || big_c) mag_c = '0;
      x_c = neg_c ? -$signed(mag_c) : $signed(mag_c);
   end

   logic                  vld_q;
   logic signed [X_W-1:0] x_q;
   exr_cls_t              cls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         x_q   <= '0;
         cls_q <= '0;
      end else begin
         vld_q <= vld_i;
         x_q   <= x_c;
         cls_q <= '{nan: nan_c, big: big_c, neg: neg_c};
      end
   end

   logic [BND_W-1:0] bnd_q;

   exr_delay #(.W(BND_W), .N(LAT-1)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({vld_q, cls_q, x_q}),
      .q     (bnd_q)
   );

   assign vld_o = bnd_q[BND_W-1];
   assign cls_o = bnd_q[X_W +: CLS_W];
   assign x_o   = $signed(bnd_q[X_W-1:0]);

   AST_TINY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && (op_i[FP_W-2 -: EXP_W] < EXP_W'(TINY_E))) |=> (x_q == '0)); // R5

endmodule

// File: rtl/exr_scale.sv
module exr_scale
   import exr_pkg::*;
#(
   parameter int INT_W  = 11,
   parameter int FRAC_W = 60,
   parameter int LAT    = 2,
   localparam int X_W   = INT_W + FRAC_W + 1,
   localparam int XI_W  = INT_W + 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vld_i,
   input  logic signed [X_W-1:0]  x_i,
   input  exr_cls_t               cls_i,
   output logic                   vld_o,
   output logic signed [X_W-1:0]  x_o,
   output logic signed [XI_W-1:0] xi_o,
   output exr_cls_t               cls_o
);

   localparam int PR_W  = X_W + L2E_FB + 2;
   localparam int SH    = FRAC_W + L2E_FB;
   localparam int BND_W = 1 + CLS_W + X_W + XI_W;
   localparam logic signed [PR_W-1:0] K_L2E = PR_W'($signed({1'b0, LOG2E_Q64}));

   // stage 1: full product, stage 2: floor by arithmetic shift
   logic                   v1_q, v2_q;
   logic signed [PR_W-1:0] p_q;
   logic signed [X_W-1:0]  x1_q, x2_q;
   logic signed [XI_W-1:0] xi_q;
   exr_cls_t               c1_q, c2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q <= 1'b0;  v2_q <= 1'b0;
         p_q  <= '0;    xi_q <= '0;
         x1_q <= '0;    x2_q <= '0;
         c1_q <= '0;    c2_q <= '0;
      end else begin
         v1_q <= vld_i;
         p_q  <= PR_W'(x_i) * K_L2E;
         x1_q <= x_i;
         c1_q <= cls_i;
         v2_q <= v1_q;
         xi_q <= XI_W'(p_q >>> SH);
         x2_q <= x1_q;
         c2_q <= c1_q;
      end
   end

   logic [BND_W-1:0] bnd_q;

   exr_delay #(.W(BND_W), .N(LAT-2)) u_pad (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({v2_q, c2_q, xi_q, x2_q}),
      .q     (bnd_q)
   );

   assign vld_o = bnd_q[BND_W-1];
   assign cls_o = bnd_q[X_W+XI_W +: CLS_W];
   assign xi_o  = $signed(bnd_q[X_W +: XI_W]);
   assign x_o   = $signed(bnd_q[X_W-1:0]);

   AST_SCALE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |-> ##2 v2_q); // R8

endmodule

// File: rtl/exr_reduce.sv
module exr_reduce
   import exr_pkg::*;
#(
   parameter int INT_W  = 11,
   parameter int FRAC_W = 60,
   parameter int ADDR_W = 9,
   localparam int N_TBL = 3,
   localparam int TAY_W = FRAC_W - N_TBL*ADDR_W,
   localparam int X_W   = INT_W + FRAC_W + 1,
   localparam int XI_W  = INT_W + 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      vld_i,
   input  logic signed [X_W-1:0]     x_i,
   input  logic signed [XI_W-1:0]    xi_i,
   input  exr_cls_t                  cls_i,
   output logic                      vld_o,
   output logic signed [INT_W-1:0]   int_o,
   output logic [N_TBL*ADDR_W-1:0]   addr_o,
   output logic [TAY_W-1:0]          tay_o,
   output logic                      nan_o,
   output logic                      ovf_o,
   output logic                      unf_o
);

   localparam int GUARD = LN2_FB - FRAC_W;
   localparam int PW    = X_W + GUARD + 4;
   localparam logic signed [PW-1:0]   LN2_P  = $signed(PW'(LN2_Q72));
   localparam logic signed [XI_W-1:0] XI_MAX = XI_W'((2**(INT_W-1)) - 1);
   localparam logic signed [XI_W-1:0] XI_MIN = -XI_W'(2**(INT_W-1));
   localparam logic [FRAC_W-1:0]      LN2_F  = LN2_Q72[LN2_FB-1 -: FRAC_W];

   // stage A: raw remainder from the estimated integer
   logic                   va_q;
   logic signed [PW-1:0]   r0_q;
   logic signed [XI_W-1:0] xi0_q;
   exr_cls_t               ca_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q  <= 1'b0;
         r0_q  <= '0;
         xi0_q <= '0;
         ca_q  <= '0;
      end else begin
         va_q  <= vld_i;
         r0_q  <= (PW'(x_i) <<< GUARD) - PW'(xi_i) * LN2_P;
         xi0_q <= xi_i;
         ca_q  <= cls_i;
      end
   end

   // stage B: one-step correction into [0, ln2), range check, split
   logic signed [XI_W-1:0] xi_c;
   logic signed [PW-1:0]   r_c;
   logic [FRAC_W-1:0]      frac_c;
   logic [N_TBL*ADDR_W-1:0] addr_c;
   logic                   nan_c, ovf_c, unf_c, kill_c;

   always_comb begin
      xi_c = xi0_q;
      r_c  = r0_q;
      if (r0_q[PW-1]) begin
         xi_c = xi0_q - XI_W'(1);
         r_c  = r0_q + LN2_P;
      end else if (r0_q >= LN2_P) begin
         xi_c = xi0_q + XI_W'(1);
         r_c  = r0_q - LN2_P;
      end
      frac_c = FRAC_W'(r_c >>> GUARD);
      nan_c  = ca_q.nan;
      ovf_c  = !ca_q.nan && (ca_q.big ? !ca_q.neg : (xi_c > XI_MAX));
      unf_c  = !ca_q.nan && (ca_q.big ?  ca_q.neg : (xi_c < XI_MIN));
      kill_c = nan_c || ovf_c || unf_c;
   end

   generate
      for (genvar g = 0; g < N_TBL; g++) begin : g_field
         assign addr_c[(N_TBL-1-g)*ADDR_W +: ADDR_W] = frac_c[FRAC_W-1-g*ADDR_W -: ADDR_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         int_o  <= '0;
         addr_o <= '0;
         tay_o  <= '0;
         nan_o  <= 1'b0;
         ovf_o  <= 1'b0;
         unf_o  <= 1'b0;
      end else begin
         vld_o  <= va_q;
         int_o  <= kill_c ? '0 : xi_c[INT_W-1:0];
         addr_o <= kill_c ? '0 : addr_c;
         tay_o  <= kill_c ? '0 : frac_c[TAY_W-1:0];
         nan_o  <= va_q && nan_c;
         ovf_o  <= va_q && ovf_c;
         unf_o  <= va_q && unf_c;
      end
   end

   AST_FRAC_BELOW_LN2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !(nan_o || ovf_o || unf_o)) |-> ({addr_o, tay_o} <= LN2_F)); // R3
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nan_o, ovf_o, unf_o})); // R7
   AST_FLAG_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (nan_o || ovf_o || unf_o) |-> (int_o == '0 && addr_o == '0 && tay_o == '0)); // R6
   AST_REDUCE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |-> ##2 vld_o); // R8
   AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> !(nan_o || ovf_o || unf_o)); // R9

endmodule

// File: rtl/exr_arg_reduce.sv
module exr_arg_reduce
   import exr_pkg::*;
#(
   parameter int INT_W    = 11,
   parameter int FRAC_W   = 60,
   parameter int ADDR_W   = 9,
   parameter int CONV_LAT = 5,
   parameter int MUL_LAT  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [63:0]                    in_op,
   output logic                           out_valid,
   output logic signed [INT_W-1:0]        out_int,
   output logic [ADDR_W-1:0]              out_tbl_hi,
   output logic [ADDR_W-1:0]              out_tbl_mid,
   output logic [ADDR_W-1:0]              out_tbl_lo,
   output logic [FRAC_W-3*ADDR_W-1:0]     out_taylor,
   output logic                           out_nan,
   output logic                           out_ovf,
   output logic                           out_unf
);

   localparam int X_W  = INT_W + FRAC_W + 1;
   localparam int XI_W = INT_W + 3;

   generate
      if (FRAC_W > 60 || FRAC_W < 3*ADDR_W + 1) begin : g_bad_frac
         $error("exr_arg_reduce: FRAC_W out of supported range");
      end
      if (INT_W < 2 || INT_W > 11) begin : g_bad_int
         $error("exr_arg_reduce: INT_W must be 2..11");
      end
      if (CONV_LAT < 1 || MUL_LAT < 2) begin : g_bad_lat
         $error("exr_arg_reduce: stage latencies too small");
      end
   endgenerate

   logic                   u_vld, s_vld;
   logic signed [X_W-1:0]  u_x, s_x;
   logic signed [XI_W-1:0] s_xi;
   exr_cls_t               u_cls, s_cls;
   logic [3*ADDR_W-1:0]    addr;

   exr_unpack #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LAT(CONV_LAT)) u_unpack (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .op_i  (in_op),
      .vld_o (u_vld),
      .x_o   (u_x),
      .cls_o (u_cls)
   );

   exr_scale #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LAT(MUL_LAT)) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (u_vld),
      .x_i   (u_x),
      .cls_i (u_cls),
      .vld_o (s_vld),
      .x_o   (s_x),
      .xi_o  (s_xi),
      .cls_o (s_cls)
   );

   exr_reduce #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_reduce (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s_vld),
      .x_i    (s_x),
      .xi_i   (s_xi),
      .cls_i  (s_cls),
      .vld_o  (out_valid),
      .int_o  (out_int),
      .addr_o (addr),
      .tay_o  (out_taylor),
      .nan_o  (out_nan),
      .ovf_o  (out_ovf),
      .unf_o  (out_unf)
   );

   assign out_tbl_hi  = addr[3*ADDR_W-1 -: ADDR_W];
   assign out_tbl_mid = addr[2*ADDR_W-1 -: ADDR_W];
   assign out_tbl_lo  = addr[ADDR_W-1:0];

endmodule

// File: tb/exr_arg_reduce_bench.sv
`timescale 1ns/1ps
module exr_arg_reduce_bench;

   localparam int G = 12;  // 72 - 60 guard bits for the exact check

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_op = '0;
   logic        out_valid;
   logic signed [10:0] out_int;
   logic [8:0]  out_tbl_hi, out_tbl_mid, out_tbl_lo;
   logic [32:0] out_taylor;
   logic        out_nan, out_ovf, out_unf;

   always #2 clk = ~clk;

   exr_arg_reduce u_exr_arg_reduce (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .out_valid(out_valid), .out_int(out_int), .out_tbl_hi(out_tbl_hi),
      .out_tbl_mid(out_tbl_mid), .out_tbl_lo(out_tbl_lo), .out_taylor(out_taylor),
      .out_nan(out_nan), .out_ovf(out_ovf), .out_unf(out_unf)
   );

   localparam logic signed [99:0] LN2B = $signed({28'd0, 72'hB17217F7D1CF79ABCA});

   int n_tests = 0, n_fail = 0;
   int wr = 0, rd = 0;
   bit done = 0;
   logic [63:0] ops [0:4095];

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // fixed-point value trunc(x * 2^60) with sign, computed from the bit fields
   function automatic logic signed [99:0] fix_of(input logic [63:0] op);
      logic [10:0] e;
      logic [99:0] mag;
      int sh;
      e = op[62:52];
      if (e == 0) mag = '0;
      else begin
         mag = {47'd0, 1'b1, op[51:0]};
         sh  = int'(e) - 1015;
         if (sh >= 0) mag = mag << sh;
         else         mag = mag >> (-sh);
      end
      return op[63] ? -$signed(mag) : $signed(mag);
   endfunction

   task automatic check_one(input logic [63:0] op);
      logic [10:0] e;
      bit nan, big;
      logic signed [99:0] num, q, rem, recon, frac, d;
      logic [59:0] efrac, afrac;
      logic [59:0] zero60;
      zero60 = '0;
      e   = op[62:52];
      nan = (e == 11'h7FF) && (op[51:0] != 0);
      big = !nan && (e >= 11'd1034);
      afrac = {out_tbl_hi, out_tbl_mid, out_tbl_lo, out_taylor};
      if (nan) begin
         chk(out_nan && !out_ovf && !out_unf, "R6 nan flag", {out_nan, out_ovf, out_unf}, 3'b100);
         chk(out_int == 0 && afrac == zero60, "R6 nan data zero", afrac, 0);
      end else if (big) begin
         chk(out_ovf == !op[63] && out_unf == op[63] && !out_nan, "R7 huge operand flag",
             {out_nan, out_ovf, out_unf}, {1'b0, !op[63], op[63]});
         chk(out_int == 0 && afrac == zero60, "R7 huge data zero", afrac, 0);
      end else begin
         num = fix_of(op) <<< G;
         q   = num / LN2B;
         rem = num - q * LN2B;
         if (rem < 0) begin
            q   = q - 1;
            rem = rem + LN2B;
         end
         efrac = 60'(rem >>> G);
         if (q > 1023 || q < -1024) begin
            chk(out_ovf == (q > 1023) && out_unf == (q < -1024) && !out_nan,
                "R7 range flag", {out_nan, out_ovf, out_unf}, {1'b0, q > 1023, q < -1024});
            chk(out_int == 0 && afrac == zero60, "R7 range data zero", afrac, 0);
         end else begin
            chk(!out_nan && !out_ovf && !out_unf, "R7 no flag in range",
                {out_nan, out_ovf, out_unf}, 0);
            if (num == 0)
               chk(out_int == 0 && afrac == zero60, "R5 tiny operand is zero", afrac, 0);
            chk(out_int == q, "R2 integer part", 128'(out_int), 128'(q));
            chk(out_tbl_hi == efrac[59:51] && out_tbl_mid == efrac[50:42] &&
                out_tbl_lo == efrac[41:33], "R4 table fields",
                {out_tbl_hi, out_tbl_mid, out_tbl_lo}, efrac[59:33]);
            chk(out_taylor == efrac[32:0], "R4 taylor field", out_taylor, efrac[32:0]);
            frac  = $signed({40'd0, afrac});
            recon = out_int * LN2B + (frac <<< G);
            d     = num - recon;
            chk(d >= 0 && d < (100'sd1 <<< G), "R1 reconstruction within 1 LSB", d, 0);
            chk((frac <<< G) < LN2B, "R3 fraction below ln2", afrac, 60'(LN2B >>> G));
         end
      end
   endtask

   // scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (rd >= wr) chk(0, "R9 output without input", rd, wr);
         else begin
            check_one(ops[rd]);
            rd++;
         end
      end
   end

   task automatic send(input logic [63:0] op);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      ops[wr]  = op;
      wr++;
      if (wr % 13 == 0) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   function automatic logic [51:0] mpat(input int j);
      case (j)
         0: return 52'h0;
         1: return 52'hFFFFFFFFFFFFF;
         2: return 52'h8000000000000;
         3: return 52'h5555555555555;
         4: return 52'hAAAAAAAAAAAAA;
         5: return 52'h0000000000001;
         6: return 52'h123456789ABCD;
         default: return 52'hFEDCBA9876543;
      endcase
   endfunction

   initial begin
      int lat;
      logic [63:0] b;
      repeat (4) @(negedge clk);
      chk(out_valid == 0 && out_int == 0 && out_nan == 0 && out_ovf == 0 && out_unf == 0,
          "R9 reset state", {out_valid, out_nan, out_ovf, out_unf}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_valid == 0, "R9 idle after reset", out_valid, 0);

      // latency: operand 1.0
      @(negedge clk);
      in_valid = 1'b1; in_op = 64'h3FF0000000000000;
      ops[wr] = in_op; wr++;
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      while (!out_valid && lat < 30) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == 9, "R8 latency", lat, 9);
      repeat (3) @(negedge clk);

      // specials
      send(64'h0000000000000000);  // +0
      send(64'h8000000000000000);  // -0
      send(64'h000FFFFFFFFFFFFF);  // subnormal
      send(64'h0010000000000000);  // min normal
      send({1'b0, 11'd962, 52'hFFFFFFFFFFFFF}); // just below 2^-60
      send({1'b0, 11'd963, 52'h0});             // 2^-60
      send({1'b1, 11'd963, 52'h0});             // -2^-60
      send(64'h7FF0000000000000);  // +inf
      send(64'hFFF0000000000000);  // -inf
      send(64'h7FF8000000000000);  // quiet NaN
      send(64'hFFF0000000000001);  // signalling NaN
      send(64'h7FEFFFFFFFFFFFFF);  // largest finite
      send({1'b0, 11'd1033, 52'hFFFFFFFFFFFFF});
      send({1'b1, 11'd1033, 52'hFFFFFFFFFFFFF});

      // exponent / mantissa / sign sweep, back to back
      for (int e = 950; e <= 1040; e++)
         for (int j = 0; j < 8; j++)
            for (int s = 0; s < 2; s++)
               send({s[0], e[10:0], mpat(j)});

      // multiples of ln2 and one ulp either side
      for (int k = -1100; k <= 1100; k += 9) begin
         if (k != 0) begin
            b = $realtobits(real'(k) * 0.6931471805599453);
            send(b);
            send(b + 64'd1);
            send(b - 64'd1);
         end
      end

      @(negedge clk);
      in_valid = 1'b0;
      for (int w = 0; w < 40 && rd < wr; w++) @(negedge clk);
      chk(rd == wr, "R8 one result per operand", rd, wr);
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog expired: results %0d of %0d", rd, wr);
      finish_up();
   end

endmodule